// File: doc/BRIEF.md
# Add/Subtract Unit with Flags

This block is a purely combinational two's-complement arithmetic unit of parameterised width. A single select input chooses between A + B and A − B. Subtraction is not built as separate hardware. The B operand is inverted bit by bit and a carry of one is injected at the least significant position of the same ripple adder.

Beside the result, the unit reports four condition bits: carry, zero, negative and overflow. It also turns those bits into ten relation outputs between A and B, six signed and four unsigned. The relation outputs are decoded only from the condition bits, so they are meaningful when the unit is subtracting. In add mode they still follow the same decode of the current flags.

When subtracting, the carry bit is reported as a borrow. It is set when A is unsigned-less than B. This makes the unsigned relations read directly from it.

Top module: `addsub_flags_unit`

## Requirements
- R1: With the subtract select low, the result equals (A + B) modulo 2^WIDTH, and B enters the adder unchanged with a carry-in of 0.
- R2: With the subtract select high, the result equals (A − B) modulo 2^WIDTH, formed as A + ~B + 1.
- R3: With the subtract select low, the carry flag is the carry out of the most significant adder position. With it high, the carry flag is a borrow, set exactly when A < B as unsigned numbers.
- R4: The zero flag is 1 exactly when every result bit is 0.
- R5: The negative flag equals the most significant result bit.
- R6: The overflow flag is 1 exactly when the true signed sum or difference lies outside −2^(WIDTH−1) … 2^(WIDTH−1)−1. This is the same as the XOR of the carry into and out of the top adder position.
- R7: When subtracting, the signed relations are decoded from the flags: less-than = N xor V, less-or-equal = Z or (N xor V), greater-or-equal = not (N xor V), greater-than = not (Z or (N xor V)). They match the signed comparison of A and B.
- R8: The equal output equals Z and the not-equal output equals not Z. When subtracting, this is A == B.
- R9: When subtracting, the unsigned relations are: below = C, below-or-equal = C or Z, above-or-equal = not C, above = not (C or Z). They match the unsigned comparison of A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | WIDTH | First operand |
| op_b_i | input | WIDTH | Second operand |
| sub_i | input | 1 | 1 selects A − B, 0 selects A + B |
| res_o | output | WIDTH | Sum or difference |
| c_o | output | 1 | Carry (add) or borrow (subtract) |
| z_o | output | 1 | Result is all zeros |
| n_o | output | 1 | Result sign bit |
| v_o | output | 1 | Signed overflow |
| lt_o | output | 1 | Signed A < B |
| le_o | output | 1 | Signed A <= B |
| ge_o | output | 1 | Signed A >= B |
| gt_o | output | 1 | Signed A > B |
| eq_o | output | 1 | A == B |
| ne_o | output | 1 | A != B |
| ltu_o | output | 1 | Unsigned A < B |
| leu_o | output | 1 | Unsigned A <= B |
| geu_o | output | 1 | Unsigned A >= B |
| gtu_o | output | 1 | Unsigned A > B |

## Verification
The unit is driven with a fixed vector set around the sign boundary: the most negative value, the largest positive value, zero, all ones and equal operands. These separate the overflow decode from the carry decode, and the borrow sense from a raw carry out. Add vectors that carry out without overflow, and the reverse, show that C and V are not swapped. Subtractions of 0x80 and from 0x80 expose an overflow rule that ignores the inverted B sign. Several hundred random operand pairs in both modes are then compared with an integer reference that works on the true signed and unsigned values rather than on the flags.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;

  function automatic logic fa_sum(input logic a, input logic b, input logic ci);
    return a ^ b ^ ci;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic ci);
    return (a & b) | ((a ^ b) & ci);
  endfunction

  // overflow when both adder inputs share a sign that the result lacks
  function automatic logic sign_overflow(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

endpackage

// File: rtl/addsub_operand.sv
module addsub_operand #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] b_eff_o,
  output logic             cin_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_inv
    assign b_eff_o[i] = b_i[i] ^ sub_i;
  end
  assign cin_o = sub_i;
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH:0]   carry_o
);
  import addsub_pkg::*;

  assign carry_o[0] = cin_i;
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    assign sum_o[i]     = fa_sum(a_i[i], b_i[i], carry_o[i]);
    assign carry_o[i+1] = fa_carry(a_i[i], b_i[i], carry_o[i]);
  end
endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]     res_i,
  input  logic                 a_msb_i,
  input  logic                 b_eff_msb_i,
  input  logic                 cout_i,
  input  logic                 sub_i,
  output addsub_pkg::flags_t   flags_o
);
  import addsub_pkg::*;

  always_comb begin
    flags_o.c = cout_i ^ sub_i;
    flags_o.z = ~|res_i;
    flags_o.n = res_i[WIDTH-1];
    flags_o.v = sign_overflow(a_msb_i, b_eff_msb_i, res_i[WIDTH-1]);
  end
endmodule

// File: rtl/addsub_cmp_decode.sv
module addsub_cmp_decode (
  input  addsub_pkg::flags_t flags_i,
  output logic lt_o,
  output logic le_o,
  output logic ge_o,
  output logic gt_o,
  output logic eq_o,
  output logic ne_o,
  output logic ltu_o,
  output logic leu_o,
  output logic geu_o,
  output logic gtu_o
);
  logic sgn_less;
  logic ule;

  assign sgn_less = flags_i.n ^ flags_i.v;
  assign lt_o     = sgn_less;
  assign le_o     = flags_i.z | sgn_less;
  assign ge_o     = ~sgn_less;
  assign gt_o     = ~(flags_i.z | sgn_less);
  assign eq_o     = flags_i.z;
  assign ne_o     = ~flags_i.z;
  assign ule      = flags_i.c | flags_i.z;
  assign ltu_o    = flags_i.c;
  assign leu_o    = ule;
  assign geu_o    = ~flags_i.c;
  assign gtu_o    = ~ule;
endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o,
  output logic             z_o,
  output logic             n_o,
  output logic             v_o,
  output logic             lt_o,
  output logic             le_o,
  output logic             ge_o,
  output logic             gt_o,
  output logic             eq_o,
  output logic             ne_o,
  output logic             ltu_o,
  output logic             leu_o,
  output logic             geu_o,
  output logic             gtu_o
);
  import addsub_pkg::*;

  localparam int MSB = WIDTH - 1;

  // named internal events for the checker
  logic [WIDTH-1:0] b_eff;
  logic             carry_in0;
  logic [WIDTH:0]   carry_chain;
  logic             carry_into_msb;
  logic             carry_out_msb;
  flags_t           flags;

  addsub_operand #(.WIDTH(WIDTH)) u_operand (
    .b_i     (op_b_i),
    .sub_i   (sub_i),
    .b_eff_o (b_eff),
    .cin_o   (carry_in0)
  );

  addsub_ripple #(.WIDTH(WIDTH)) u_ripple (
    .a_i     (op_a_i),
    .b_i     (b_eff),
    .cin_i   (carry_in0),
    .sum_o   (res_o),
    .carry_o (carry_chain)
  );

  assign carry_into_msb = carry_chain[MSB];
  assign carry_out_msb  = carry_chain[WIDTH];

  addsub_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .res_i       (res_o),
    .a_msb_i     (op_a_i[MSB]),
    .b_eff_msb_i (b_eff[MSB]),
    .cout_i      (carry_out_msb),
    .sub_i       (sub_i),
    .flags_o     (flags)
  );

  assign c_o = flags.c;
  assign z_o = flags.z;
  assign n_o = flags.n;
  assign v_o = flags.v;

  addsub_cmp_decode u_cmp (
    .flags_i (flags),
    .lt_o    (lt_o),
    .le_o    (le_o),
    .ge_o    (ge_o),
    .gt_o    (gt_o),
    .eq_o    (eq_o),
    .ne_o    (ne_o),
    .ltu_o   (ltu_o),
    .leu_o   (leu_o),
    .geu_o   (geu_o),
    .gtu_o   (gtu_o)
  );
endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a_i,
  input logic [WIDTH-1:0] op_b_i,
  input logic             sub_i,
  input logic [WIDTH-1:0] res_o,
  input logic             c_o,
  input logic             z_o,
  input logic             n_o,
  input logic             v_o,
  input logic             lt_o,
  input logic             le_o,
  input logic             ge_o,
  input logic             eq_o,
  input logic             ne_o,
  input logic             ltu_o,
  input logic             leu_o,
  input logic             geu_o,
  input logic [WIDTH-1:0] b_eff,
  input logic             carry_in0,
  input logic             carry_into_msb,
  input logic             carry_out_msb
);
  always_comb begin
    // R1: add mode passes B unchanged, carry-in 0
    a_r1_add_passthru: assert (sub_i || (b_eff == op_b_i && !carry_in0));
    // R2: subtract mode inverts B and injects one
    a_r2_sub_invert: assert (!sub_i || (b_eff == ~op_b_i && carry_in0));
    // R3: carry flag against the raw adder carry out
    a_r3_carry_sense: assert (c_o == (carry_out_msb ^ sub_i));
    // R4: zero flag against the result bus
    a_r4_zero: assert (z_o == (res_o == '0));
    // R5: negative flag against the result sign
    a_r5_negative: assert (n_o == res_o[WIDTH-1]);
    // R6: sign-rule overflow agrees with carry-chain overflow
    a_r6_overflow: assert (v_o == (carry_into_msb ^ carry_out_msb));
    // R7: signed less-than and greater-or-equal are complementary, le covers lt
    a_r7_signed_pair: assert ((lt_o ^ ge_o) && (!lt_o || le_o));
    // R8: equal and not-equal are complementary
    a_r8_eq_ne: assert (eq_o ^ ne_o);
    // R9: unsigned below and above-or-equal are complementary, leu covers ltu
    a_r9_unsigned_pair: assert ((ltu_o ^ geu_o) && (!ltu_o || leu_o));
  end
endmodule

bind addsub_flags_unit addsub_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a_i         (op_a_i),
  .op_b_i         (op_b_i),
  .sub_i          (sub_i),
  .res_o          (res_o),
  .c_o            (c_o),
  .z_o            (z_o),
  .n_o            (n_o),
  .v_o            (v_o),
  .lt_o           (lt_o),
  .le_o           (le_o),
  .ge_o           (ge_o),
  .eq_o           (eq_o),
  .ne_o           (ne_o),
  .ltu_o          (ltu_o),
  .leu_o          (leu_o),
  .geu_o          (geu_o),
  .b_eff          (b_eff),
  .carry_in0      (carry_in0),
  .carry_into_msb (carry_into_msb),
  .carry_out_msb  (carry_out_msb)
);

// File: tb/addsub_flags_unit_bench.sv
module addsub_flags_unit_bench;
  localparam int W = 8;
  localparam int NVEC = 16;
  localparam int NRAND = 400;

  // {a, b, sub}
  localparam logic [2*W:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 1'b0}, {8'h7F, 8'h01, 1'b0}, {8'hFF, 8'h01, 1'b0},
    {8'h80, 8'h80, 1'b0}, {8'h40, 8'h40, 1'b0}, {8'hC0, 8'hC0, 1'b0},
    {8'h80, 8'h01, 1'b1}, {8'h00, 8'h80, 1'b1}, {8'h05, 8'h05, 1'b1},
    {8'h03, 8'h07, 1'b1}, {8'hFF, 8'h01, 1'b1}, {8'h7F, 8'h80, 1'b1},
    {8'h80, 8'h7F, 1'b1}, {8'h00, 8'h01, 1'b1}, {8'hFF, 8'hFF, 1'b1},
    {8'h80, 8'h80, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a, b;
  logic sub;
  logic [W-1:0] res;
  logic c, z, n, v, lt, le, ge, gt, eq, ne, ltu, leu, geu, gtu;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addsub_flags_unit #(.WIDTH(W)) u_addsub_flags_unit (
    .op_a_i(a), .op_b_i(b), .sub_i(sub), .res_o(res),
    .c_o(c), .z_o(z), .n_o(n), .v_o(v),
    .lt_o(lt), .le_o(le), .ge_o(ge), .gt_o(gt), .eq_o(eq), .ne_o(ne),
    .ltu_o(ltu), .leu_o(leu), .geu_o(geu), .gtu_o(gtu)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h sub=%0b actual=%0d expected=%0d", tag, a, b, sub, act, exp);
    end
  endtask

  task automatic run_one(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic ts);
    int ua, ub, sa, sb, exact, uexact, eres;
    @(negedge clk);
    a = ta; b = tb; sub = ts;
    #1;
    ua = int'(ta); ub = int'(tb);
    sa = ua - (ta[W-1] ? (1 << W) : 0);
    sb = ub - (tb[W-1] ? (1 << W) : 0);
    exact  = ts ? sa - sb : sa + sb;
    uexact = ts ? ua - ub : ua + ub;
    eres   = uexact & ((1 << W) - 1);
    if (ts) chk("R2 result", int'(res), eres);
    else    chk("R1 result", int'(res), eres);
    chk("R3 carry", int'(c), ts ? int'(ua < ub) : int'(uexact >= (1 << W)));
    chk("R4 zero", int'(z), int'(eres == 0));
    chk("R5 negative", int'(n), (eres >> (W-1)) & 1);
    chk("R6 overflow", int'(v), int'(exact < -(1 << (W-1)) || exact > (1 << (W-1)) - 1));
    if (ts) begin
      chk("R7 lt", int'(lt), int'(sa < sb));
      chk("R7 le", int'(le), int'(sa <= sb));
      chk("R7 ge", int'(ge), int'(sa >= sb));
      chk("R7 gt", int'(gt), int'(sa > sb));
      chk("R8 eq", int'(eq), int'(ua == ub));
      chk("R8 ne", int'(ne), int'(ua != ub));
      chk("R9 ltu", int'(ltu), int'(ua < ub));
      chk("R9 leu", int'(leu), int'(ua <= ub));
      chk("R9 geu", int'(geu), int'(ua >= ub));
      chk("R9 gtu", int'(gtu), int'(ua > ub));
    end else begin
      chk("R8 eq tracks zero in add mode", int'(eq), int'(eres == 0));
    end
  endtask

  initial begin
    a = '0; b = '0; sub = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state check: zero operands in add mode
    @(negedge clk);
    chk("R4 idle zero", int'(z), 1);
    chk("R1 idle result", int'(res), 0);
    for (int i = 0; i < NVEC; i++) begin
      run_one(VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0]);
    end
    // directed corners: most negative, zero, all ones against each other
    run_one(8'h80, 8'h00, 1'b1);
    run_one(8'h00, 8'hFF, 1'b1);
    run_one(8'hFF, 8'h80, 1'b1);
    run_one(8'hFF, 8'hFF, 1'b0);
    run_one(8'h01, 8'hFF, 1'b0);
    for (int k = 0; k < NRAND; k++) begin
      run_one(W'($urandom), W'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule